// File: doc/BRIEF.md
# Bank-Switched Indirect Storage Window

This block puts a 128-byte storage array behind a small register window on a host bus that shares its address and data lines. The host drives an offset on the shared input with an address-latch strobe. It then issues a read or write strobe, and the block acts on the latched offset. The block holds one register for the latched offset and one register for the data byte.

The array cannot be reached directly. The host first sets a bank-enable bit in a primary control register. This opens a secondary bank of registers. The host then loads a 7-bit pointer into the pointer register and moves bytes through a data-port register. The pointer keeps its value across data-port traffic, so one location can be read or written many times in a row. While the bank-enable bit is clear, the pointer and data-port offsets belong to the primary bank, and accesses there do not touch the pointer or the array.

Top module: `xram_window`

## Requirements
- R1: After reset the control register is 00h, the pointer is 00h, ad_oe is 0 and ad_out is 00h.
- R2: The control register sits at offset 0Ah in both banks. All 8 bits can be written and read back. Bit 4 is the bank-enable bit, and a value of 1 selects the secondary bank.
- R3: With bit 4 set, a write to offset 50h loads bits 6:0 into the pointer and ignores bit 7. A read of 50h returns the pointer with bit 7 equal to 0.
- R4: With bit 4 set, a read of offset 53h returns the array byte that the pointer addresses.
- R5: With bit 4 set, a write to offset 53h stores the written byte at the array location that the pointer addresses. Locations 00h and 7Fh are both reachable.
- R6: Reads and writes of offset 53h leave the pointer unchanged, so repeated accesses hit the same location.
- R7: With bit 4 clear, reads of offsets 50h and 53h return 00h. Writes to those offsets change neither the pointer nor the array.
- R8: With bit 4 set, offsets other than 0Ah, 50h and 53h read as 00h, and writes to them have no effect.
- R9: Reset does not alter the array contents.
- R10: A cycle with ale high latches ad_in as the offset. A read or write strobe acts on the offset latched by the most recent earlier ale cycle, even if ale is high in the same cycle. When both strobes are high, the write is performed and the read is dropped.
- R11: ad_oe is 1 in exactly the cycle after a performed read strobe. In that cycle ad_out holds the read byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address-latch strobe; captures ad_in as the offset |
| rd_en | input | 1 | Read strobe for the latched offset |
| wr_en | input | 1 | Write strobe; ad_in carries the data byte |
| ad_in | input | 8 | Shared offset/data input lines |
| ad_out | output | 8 | Data register contents (the read result) |
| ad_oe | output | 1 | High in the cycle that ad_out carries a read result |

## Verification
The bench reads the pointer after writing a value with bit 7 set. A design that kept that bit would return 85h where 05h is expected. The bench writes the pointer and data-port offsets with the bank closed, then reopens the bank. A decoder that ignored the bank bit would show a moved pointer or a changed array byte at that point. The bench also drives both strobes together, and drives ale together with a write. A block that let the read win, or that used the offset arriving in that same cycle, would store the byte in the wrong place. The bench pulses reset between array writes and reads. A design that cleared its storage on reset would lose bytes at locations 00h and 7Fh.

// File: rtl/xram_pkg.sv
package xram_pkg;

  // Decoded target of the latched offset.
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CTRL = 2'd1,
    TGT_PTR  = 2'd2,
    TGT_PORT = 2'd3
  } tgt_e;

  // The control register is visible in both banks; pointer and port only
  // while the secondary bank is open.
  function automatic tgt_e decode_tgt(
    input logic [7:0] ofs,
    input logic       bank_on,
    input logic [7:0] ctrl_ofs,
    input logic [7:0] ptr_ofs,
    input logic [7:0] port_ofs
  );
    tgt_e t;
    t = TGT_NONE;
    if (ofs == ctrl_ofs)                t = TGT_CTRL;
    else if (bank_on && ofs == ptr_ofs)  t = TGT_PTR;
    else if (bank_on && ofs == port_ofs) t = TGT_PORT;
    return t;
  endfunction

endpackage

// File: rtl/xram_bus_latch.sv
module xram_bus_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ofs_q,
  output logic          rd_go,
  output logic          wr_go
);

  // Offset register: the strobes see the value from earlier ale cycles.
  always_ff @(posedge clk) begin
    if (!rst_n)   ofs_q <= '0;
    else if (ale) ofs_q <= ad_in;
  end

  // A write takes priority over a read in the same cycle.
  assign wr_go = wr_en;
  assign rd_go = rd_en & ~wr_en;

endmodule

// File: rtl/xram_regs.sv
module xram_regs #(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter int BANK_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          ptr_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [AW-1:0] ptr_q,
  output logic          bank_on
);

  // Pointer fold: only the low AW bits of a written byte are kept.
  function automatic logic [AW-1:0] ptr_fold(input logic [DW-1:0] b);
    return b[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_wr) ptr_q <= ptr_fold(wdata);
  end

  assign bank_on = ctrl_q[BANK_BIT];

endmodule

// File: rtl/xram_store.sv
module xram_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  // Storage has no reset so that its contents persist across it.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/xram_window.sv
module xram_window #(
  parameter int          DW       = 8,
  parameter int          DEPTH    = 128,
  parameter int          BANK_BIT = 4,
  parameter logic [7:0]  CTRL_OFS = 8'h0A,
  parameter logic [7:0]  PTR_OFS  = 8'h50,
  parameter logic [7:0]  PORT_OFS = 8'h53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe
);
  import xram_pkg::*;

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] ofs_q;
  logic          rd_go, wr_go;
  logic [DW-1:0] ctrl_q;
  logic [AW-1:0] ptr_val;
  logic          bank_on;
  logic [DW-1:0] mem_rdata;
  tgt_e          tgt;

  // Named events for the checker.
  logic ev_ctrl_wr, ev_ptr_wr, ev_port_wr;
  logic ev_ptr_rd, ev_idle_rd;

  xram_bus_latch #(.DW(DW)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .ad_in (ad_in),
    .ofs_q (ofs_q),
    .rd_go (rd_go),
    .wr_go (wr_go)
  );

  assign tgt = decode_tgt(ofs_q, bank_on, CTRL_OFS, PTR_OFS, PORT_OFS);

  assign ev_ctrl_wr = wr_go && (tgt == TGT_CTRL);
  assign ev_ptr_wr  = wr_go && (tgt == TGT_PTR);
  assign ev_port_wr = wr_go && (tgt == TGT_PORT);
  assign ev_ptr_rd  = rd_go && (tgt == TGT_PTR);
  assign ev_idle_rd = rd_go && (tgt == TGT_NONE);

  xram_regs #(.DW(DW), .AW(AW), .BANK_BIT(BANK_BIT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ev_ctrl_wr),
    .ptr_wr  (ev_ptr_wr),
    .wdata   (ad_in),
    .ctrl_q  (ctrl_q),
    .ptr_q   (ptr_val),
    .bank_on (bank_on)
  );

  xram_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (ev_port_wr),
    .addr  (ptr_val),
    .wdata (ad_in),
    .rdata (mem_rdata)
  );

  // Read multiplexer into the data register.
  logic [DW-1:0] rmux;
  always_comb begin
    unique case (tgt)
      TGT_CTRL: rmux = ctrl_q;
      TGT_PTR:  rmux = {{(DW-AW){1'b0}}, ptr_val};
      TGT_PORT: rmux = mem_rdata;
      default:  rmux = '0;
    endcase
  end

  // Data register: takes the write byte or the read result.
  logic [DW-1:0] dlat_q;
  logic          oe_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dlat_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= rd_go;
      if (wr_go)      dlat_q <= ad_in;
      else if (rd_go) dlat_q <= rmux;
    end
  end

  assign ad_out = dlat_q;
  assign ad_oe  = oe_q;

endmodule

// File: rtl/xram_window_chk.sv
module xram_window_chk #(
  parameter int DW       = 8,
  parameter int AW       = 7,
  parameter int BANK_BIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] ad_in,
  input logic [DW-1:0] ad_out,
  input logic          ad_oe,
  input logic          bank_on,
  input logic [AW-1:0] ptr_val,
  input logic          ev_ctrl_wr,
  input logic          ev_ptr_wr,
  input logic          ev_port_wr,
  input logic          ev_ptr_rd,
  input logic          ev_idle_rd
);

  a_r11_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> ad_oe);

  a_r11_oe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> !ad_oe);

  a_r2_bank_tracks_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctrl_wr |=> (bank_on == $past(ad_in[BANK_BIT])));

  a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_wr |=> (ptr_val == $past(ad_in[AW-1:0])));

  a_r3_ptr_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_rd |=> (ad_out[DW-1:AW] == '0));

  a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ptr_wr |=> $stable(ptr_val));

  a_r7_closed_bank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_on |-> !(ev_port_wr || ev_ptr_wr));

  a_r8_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle_rd |=> (ad_out == '0));

endmodule

bind xram_window xram_window_chk #(.DW(DW), .AW(AW), .BANK_BIT(BANK_BIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .ad_in      (ad_in),
  .ad_out     (ad_out),
  .ad_oe      (ad_oe),
  .bank_on    (bank_on),
  .ptr_val    (ptr_val),
  .ev_ctrl_wr (ev_ctrl_wr),
  .ev_ptr_wr  (ev_ptr_wr),
  .ev_port_wr (ev_port_wr),
  .ev_ptr_rd  (ev_ptr_rd),
  .ev_idle_rd (ev_idle_rd)
);

// File: tb/xram_window_test.sv
module xram_window_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] ad_in = 8'h00;
  logic [7:0] ad_out;
  logic       ad_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  xram_window uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .rd_en(rd_en), .wr_en(wr_en),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ale = 1'b1; ad_in = a;
    @(negedge clk); ale = 1'b0; wr_en = 1'b1; ad_in = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); ale = 1'b1; ad_in = a;
    @(negedge clk); ale = 1'b0; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = ad_out; oe = ad_oe;
  endtask

  // Vector: {req[3:0], is_read, offset[7:0], data_or_expected[7:0]}
  localparam int NV = 32;
  localparam logic [20:0] VEC [NV] = '{
    {4'd2, 1'b0, 8'h0A, 8'h10},  // R2 open bank
    {4'd2, 1'b1, 8'h0A, 8'h10},  // R2
    {4'd3, 1'b0, 8'h50, 8'h85},  // R3 bit 7 dropped
    {4'd3, 1'b1, 8'h50, 8'h05},  // R3
    {4'd5, 1'b0, 8'h53, 8'hA5},  // R5
    {4'd4, 1'b1, 8'h53, 8'hA5},  // R4
    {4'd6, 1'b1, 8'h53, 8'hA5},  // R6 repeat read
    {4'd6, 1'b1, 8'h50, 8'h05},  // R6 pointer held
    {4'd3, 1'b0, 8'h50, 8'h7F},  // R3
    {4'd5, 1'b0, 8'h53, 8'h3C},  // R5 top location
    {4'd5, 1'b1, 8'h53, 8'h3C},  // R5
    {4'd3, 1'b0, 8'h50, 8'h00},  // R3
    {4'd5, 1'b0, 8'h53, 8'hC3},  // R5 bottom location
    {4'd5, 1'b1, 8'h53, 8'hC3},  // R5
    {4'd3, 1'b0, 8'h50, 8'h7F},  // R3
    {4'd4, 1'b1, 8'h53, 8'h3C},  // R4
    {4'd8, 1'b1, 8'h51, 8'h00},  // R8
    {4'd8, 1'b0, 8'h51, 8'hFF},  // R8
    {4'd8, 1'b1, 8'h51, 8'h00},  // R8
    {4'd8, 1'b1, 8'h50, 8'h7F},  // R8 pointer untouched
    {4'd2, 1'b0, 8'h0A, 8'h00},  // R2 close bank
    {4'd2, 1'b1, 8'h0A, 8'h00},  // R2
    {4'd7, 1'b1, 8'h50, 8'h00},  // R7
    {4'd7, 1'b0, 8'h50, 8'h11},  // R7
    {4'd7, 1'b0, 8'h53, 8'hEE},  // R7
    {4'd7, 1'b1, 8'h53, 8'h00},  // R7
    {4'd2, 1'b0, 8'h0A, 8'h10},  // R2 reopen
    {4'd7, 1'b1, 8'h50, 8'h7F},  // R7 pointer unchanged
    {4'd7, 1'b1, 8'h53, 8'h3C},  // R7 array unchanged
    {4'd2, 1'b0, 8'h0A, 8'hDB},  // R2 all bits
    {4'd2, 1'b1, 8'h0A, 8'hDB},  // R2
    {4'd2, 1'b1, 8'h50, 8'h7F}   // R2 bank still open
  };

  initial begin
    logic [7:0] d;
    logic       oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ad_oe", {7'd0, ad_oe}, 8'h00);
    check("R1 ad_out", ad_out, 8'h00);
    bus_rd(8'h0A, d, oe);
    check("R1 ctrl", d, 8'h00);
    check("R11 oe on read", {7'd0, oe}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) begin
        bus_rd(VEC[i][15:8], d, oe);
        check($sformatf("R%0d vec%0d", VEC[i][20:17], i), d, VEC[i][7:0]);
      end else begin
        bus_wr(VEC[i][15:8], VEC[i][7:0]);
      end
    end

    // R10 both strobes: write wins, no output enable
    @(negedge clk); ale = 1'b1; ad_in = 8'h53;
    @(negedge clk); ale = 1'b0; wr_en = 1'b1; rd_en = 1'b1; ad_in = 8'h99;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R10 dropped read oe", {7'd0, ad_oe}, 8'h00);
    bus_rd(8'h53, d, oe);
    check("R10 write won", d, 8'h99);

    // R10 ale with a write: write goes to the earlier offset (53h)
    @(negedge clk); ale = 1'b1; wr_en = 1'b1; ad_in = 8'h50;
    @(negedge clk); ale = 1'b0; wr_en = 1'b0;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R10 new offset latched", ad_out, 8'h7F);
    @(negedge clk);
    check("R11 oe drops", {7'd0, ad_oe}, 8'h00);
    bus_rd(8'h53, d, oe);
    check("R10 write used old offset", d, 8'h50);

    // R9 array survives reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 ad_out after reset", ad_out, 8'h00);
    bus_rd(8'h0A, d, oe);
    check("R1 ctrl after reset", d, 8'h00);
    bus_wr(8'h0A, 8'h10);
    bus_rd(8'h50, d, oe);
    check("R1 pointer after reset", d, 8'h00);
    bus_rd(8'h53, d, oe);
    check("R9 location 00h kept", d, 8'hC3);
    bus_wr(8'h50, 8'hFF);
    bus_rd(8'h50, d, oe);
    check("R3 msb reads zero", d, 8'h7F);
    bus_rd(8'h53, d, oe);
    check("R9 location 7Fh kept", d, 8'h50);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule